// File: doc/BRIEF.md
# Sub-Word Store Unit with Check-Bit Read-Modify-Write and Silent-Store Suppression

This unit carries out stores into a data cache whose storage words are 64 bits wide and protected by 8 check bits. A store narrower than the full word cannot simply overwrite its bytes. The unit runs a four-step sequence instead:

1. Fetch the stored word and its check bits from the cache.
2. Repair any single-bit fault, then splice the new bytes into the repaired word.
3. Compute fresh check bits over the merged word.
4. Hand the merged word back to the cache as a write.

While the repair and the new check bits are being computed, the unit also compares the incoming bytes with the repaired old bytes. This comparison needs no extra step. When every byte matches and no fault was seen, the store is silent and the write is dropped.

A full 64-bit store does not need the old word. It goes straight to the write with freshly computed check bits. Stores that are not naturally aligned are rejected without touching the cache. A fault that cannot be repaired aborts the store and raises an error flag.

The unit takes one store at a time. The cache array sits outside the unit and answers a read request with data one cycle later.

Top module: `rmw_store_unit`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `ready` is 1 and `rd_req`, `wr_req` and `done` are 0. A store in flight when reset rises never reports `done`.
- R2: `wr_chk` is the check code of `wr_data`, defined as follows:
  - Number the code positions 1 to 71.
  - Place data bit k at the k-th position that is not a power of two.
  - Check bit j (j = 0..6) is the XOR of every data bit whose position number has bit j set.
  - Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R3: A store is accepted only on a cycle where `st_valid` and `ready` are both 1; `st_valid` while `ready` is 0 is ignored. An aligned store of size code 0, 1 or 2 has this timing:
  - `rd_req` is 1 for the single cycle after acceptance.
  - `rd_data`/`rd_chk` are sampled in the cycle after `rd_req`.
  - `done` is 1 in the cycle after that.
  - `ready` is 0 from acceptance until `done`.
- R4: Size codes 0/1/2/3 store 1/2/4/8 bytes. The store value sits in the low bytes of `st_data`. It lands in byte lanes starting at `st_addr[2:0]`, where lane n is `wr_data[8n+7:8n]`. All other lanes keep the corrected old word. `rd_addr` and `wr_addr` equal `st_addr[ADDR_W-1:3]`.
- R5: If every stored lane equals the corrected old lane and the read showed no fault, `done` comes with `silent`=1 and `wr_req`=0. Otherwise a clean sub-word store writes, with `silent`=0.
- R6: A single flipped bit, in data or check bits, is corrected before merging and comparing. `silent` reflects the comparison with the corrected word. `wr_req` is 1 even when the store is silent.
- R7: Two flipped bits give `done` with `uncorr_err`=1, `silent`=0 and `wr_req`=0.
- R8: A store whose address is not a multiple of its byte count gives `done` with `misalign`=1 one cycle after acceptance. It issues no read and no write, and `silent` is 0.
- R9: An aligned size-3 store issues no read. It gives `done` with `wr_req`=1 one cycle after acceptance, writing `st_data` with `silent`=0, even if the value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 full 64-bit |
| st_data | input | 64 | Store value, right-aligned |
| ready | output | 1 | Unit idle, store can be accepted |
| rd_req | output | 1 | Cache read request |
| rd_addr | output | ADDR_W-3 | Word address of the read |
| rd_data | input | 64 | Stored word, valid the cycle after `rd_req` |
| rd_chk | input | 8 | Stored check bits, valid with `rd_data` |
| wr_req | output | 1 | Cache write request |
| wr_addr | output | ADDR_W-3 | Word address of the write |
| wr_data | output | 64 | Word to write |
| wr_chk | output | 8 | Check bits for `wr_data` |
| done | output | 1 | Store finished this cycle |
| silent | output | 1 | Store changed no byte (valid with `done`) |
| uncorr_err | output | 1 | Uncorrectable fault on read (valid with `done`) |
| misalign | output | 1 | Store rejected as misaligned (valid with `done`) |

## Verification
The bound assertions watch, on every cycle, the following control rules:
- Read and write never coincide.
- A read is always followed by completion two cycles later.
- A write only accompanies completion.
- Rejected and aborted stores never write.
- Full stores and misaligned stores complete after one cycle.

Only the bench scenarios can show the data content. This covers the byte-lane placement of each size, the check bits against the code definition, and the repair of single flips in data and check bits. It also covers whether silence is judged on the corrected rather than the raw word, and that a store offered while busy leaves no trace.

// File: rtl/rmw_store_pkg.sv
package rmw_store_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int HAM_W  = CHK_W - 1;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } st_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_FINISH
    } state_e;

    // outcome of checking one stored word
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              single_err;
        logic              double_err;
    } dec_t;

    // captured sub-word store
    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [1:0]        size;
        logic [DATA_W-1:0] data;
    } sub_req_t;

    // code position of data bit idx: idx-th position that is not a power of two
    function automatic logic [HAM_W-1:0] data_pos(input int idx);
        int               cnt;
        logic [HAM_W-1:0] res;
        cnt = 0;
        res = '0;
        for (int p = 1; p < (1 << HAM_W); p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = HAM_W'(p);
                cnt++;
            end
        end
        return res;
    endfunction

    function automatic logic [CHK_W-1:0] ecc_gen(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        logic [HAM_W-1:0] pos;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos = data_pos(i);
            for (int j = 0; j < HAM_W; j++) begin
                if (pos[j]) c[j] = c[j] ^ d[i];
            end
        end
        c[CHK_W-1] = (^d) ^ (^c[HAM_W-1:0]);
        return c;
    endfunction

    function automatic logic misaligned(input logic [OFF_W-1:0] off, input logic [1:0] sz);
        logic [OFF_W-1:0] mask;
        mask = OFF_W'((1 << sz) - 1);
        return |(off & mask);
    endfunction

endpackage

// File: rtl/rmw_ecc_encode.sv
module rmw_ecc_encode
    import rmw_store_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CHK_W-1:0]  chk_out
);
    assign chk_out = ecc_gen(data_in);
endmodule

// File: rtl/rmw_ecc_correct.sv
module rmw_ecc_correct
    import rmw_store_pkg::*;
(
    input  logic [DATA_W-1:0] raw_data,
    input  logic [CHK_W-1:0]  raw_chk,
    output dec_t              dec
);
    logic [CHK_W-1:0]  recomputed;
    logic [HAM_W-1:0]  syndrome;
    logic              parity;
    logic [DATA_W-1:0] hit;
    logic              chk_only;

    assign recomputed = ecc_gen(raw_data);
    assign syndrome   = recomputed[HAM_W-1:0] ^ raw_chk[HAM_W-1:0];
    assign parity     = (^raw_data) ^ (^raw_chk);

    // one syndrome comparator per data bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [HAM_W-1:0] POS = data_pos(i);
        assign hit[i] = (syndrome == POS);
    end

    // zero or power-of-two syndrome: fault sits in a check bit
    assign chk_only = ((syndrome & (syndrome - HAM_W'(1))) == '0);

    always_comb begin
        dec.data       = parity ? (raw_data ^ hit) : raw_data;
        dec.single_err = parity && ((|hit) || chk_only);
        dec.double_err = (!parity && (syndrome != '0)) ||
                         (parity && !(|hit) && !chk_only);
    end
endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge
    import rmw_store_pkg::*;
(
    input  logic [DATA_W-1:0] old_data,
    input  logic [DATA_W-1:0] st_data,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] merged,
    output logic              silent
);
    localparam int CNT_W = OFF_W + 1;

    logic [DATA_W-1:0] shifted;
    logic [CNT_W-1:0]  nbytes;
    logic [CNT_W-1:0]  lo;
    logic [CNT_W-1:0]  hi;
    logic [LANES-1:0]  lane_en;
    logic [LANES-1:0]  lane_diff;

    assign shifted = st_data << {off, 3'b000};
    assign nbytes  = CNT_W'(1) << size;
    assign lo      = {1'b0, off};
    assign hi      = lo + nbytes;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_en[l]         = (CNT_W'(l) >= lo) && (CNT_W'(l) < hi);
        assign merged[8*l +: 8]   = lane_en[l] ? shifted[8*l +: 8] : old_data[8*l +: 8];
        assign lane_diff[l]       = lane_en[l] && (shifted[8*l +: 8] != old_data[8*l +: 8]);
    end

    assign silent = ~|lane_diff;
endmodule

// File: rtl/rmw_store_unit.sv
module rmw_store_unit
    import rmw_store_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               st_valid,
    input  logic [ADDR_W-1:0]  st_addr,
    input  logic [1:0]         st_size,
    input  logic [DATA_W-1:0]  st_data,
    output logic               ready,
    output logic               rd_req,
    output logic [WADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [CHK_W-1:0]   rd_chk,
    output logic               wr_req,
    output logic [WADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic [CHK_W-1:0]   wr_chk,
    output logic               done,
    output logic               silent,
    output logic               uncorr_err,
    output logic               misalign
);
    state_e             state;
    sub_req_t           req_q;
    logic [WADDR_W-1:0] waddr_q;
    logic               wr_en_q;
    logic [DATA_W-1:0]  wr_data_q;
    logic [CHK_W-1:0]   wr_chk_q;
    logic               silent_q;
    logic               uncorr_q;
    logic               misal_q;

    dec_t               dec;
    logic [DATA_W-1:0]  merged;
    logic               merge_silent;
    logic [DATA_W-1:0]  enc_in;
    logic [CHK_W-1:0]   enc_chk;
    logic [OFF_W-1:0]   in_off;

    assign in_off = st_addr[OFF_W-1:0];

    rmw_ecc_correct u_correct (
        .raw_data (rd_data),
        .raw_chk  (rd_chk),
        .dec      (dec)
    );

    rmw_lane_merge u_merge (
        .old_data (dec.data),
        .st_data  (req_q.data),
        .off      (req_q.off),
        .size     (req_q.size),
        .merged   (merged),
        .silent   (merge_silent)
    );

    // one encoder: merged word during CHECK, raw full-word store otherwise
    assign enc_in = (state == ST_CHECK) ? merged : st_data;

    rmw_ecc_encode u_encode (
        .data_in (enc_in),
        .chk_out (enc_chk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_q     <= '0;
            waddr_q   <= '0;
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
            wr_chk_q  <= '0;
            silent_q  <= 1'b0;
            uncorr_q  <= 1'b0;
            misal_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (st_valid) begin
                        waddr_q    <= st_addr[ADDR_W-1:OFF_W];
                        req_q.off  <= in_off;
                        req_q.size <= st_size;
                        req_q.data <= st_data;
                        wr_en_q    <= 1'b0;
                        silent_q   <= 1'b0;
                        uncorr_q   <= 1'b0;
                        misal_q    <= 1'b0;
                        if (misaligned(in_off, st_size)) begin
                            misal_q <= 1'b1;
                            state   <= ST_FINISH;
                        end else if (st_size == SZ_DWORD) begin
                            wr_en_q   <= 1'b1;
                            wr_data_q <= st_data;
                            wr_chk_q  <= enc_chk;
                            state     <= ST_FINISH;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: state <= ST_CHECK;
                ST_CHECK: begin
                    uncorr_q  <= dec.double_err;
                    silent_q  <= !dec.double_err && merge_silent;
                    wr_en_q   <= !dec.double_err && (!merge_silent || dec.single_err);
                    wr_data_q <= merged;
                    wr_chk_q  <= enc_chk;
                    state     <= ST_FINISH;
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign ready      = (state == ST_IDLE);
    assign rd_req     = (state == ST_READ);
    assign rd_addr    = waddr_q;
    assign done       = (state == ST_FINISH);
    assign wr_req     = done && wr_en_q;
    assign wr_addr    = waddr_q;
    assign wr_data    = wr_data_q;
    assign wr_chk     = wr_chk_q;
    assign silent     = done && silent_q;
    assign uncorr_err = done && uncorr_q;
    assign misalign   = done && misal_q;
endmodule

// File: rtl/rmw_store_unit_chk.sv
module rmw_store_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic [1:0]        st_size,
    input logic              ready,
    input logic              rd_req,
    input logic              wr_req,
    input logic              done,
    input logic              silent,
    input logic              uncorr_err,
    input logic              misalign
);
    logic bad_align;
    assign bad_align = |(st_addr[2:0] & 3'((1 << st_size) - 1));

    // R3: read and write never in the same cycle
    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    // R3: a read request is followed by completion two cycles on
    p_rd_then_done_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> ##1 done);

    // R3: busy while the read is outstanding
    p_busy_on_read_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !ready);

    // R5: a write is only issued as the store completes
    p_wr_with_done_r5: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> done);

    // R7: an uncorrectable read never writes and is never silent
    p_uncorr_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        uncorr_err |-> (done && !wr_req && !silent));

    // R8: misaligned stores complete next cycle with no read or write
    p_misalign_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && st_valid && bad_align) |=> (done && misalign && !wr_req && !rd_req));

    // R9: aligned full-word stores write on the next cycle
    p_full_write_r9: assert property (@(posedge clk) disable iff (rst)
        (ready && st_valid && st_size == 2'd3 && !bad_align) |=> (done && wr_req && !silent));

    // R1: completion returns the unit to idle
    p_idle_after_done_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);
endmodule

bind rmw_store_unit rmw_store_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rmw_store_unit_tb.sv
`timescale 1ns/1ps
module rmw_store_unit_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [1:0]    st_size = '0;
    logic [63:0]   st_data = '0;
    logic          ready, rd_req, wr_req, done, silent, uncorr_err, misalign;
    logic [AW-4:0] rd_addr, wr_addr;
    logic [63:0]   rd_data = '0;
    logic [7:0]    rd_chk = '0;
    logic [63:0]   wr_data;
    logic [7:0]    wr_chk;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rmw_store_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data), .ready(ready), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_chk(rd_chk), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk), .done(done),
        .silent(silent), .uncorr_err(uncorr_err), .misalign(misalign)
    );

    typedef struct packed {
        logic [63:0]   old;
        logic [63:0]   fdat;
        logic [7:0]    fchk;
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic [63:0]   sdat;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0010, 2'd0, 64'hEF},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0011, 2'd0, 64'h55},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0012, 2'd1, 64'h89AB},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0014, 2'd2, 64'h01234567},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0014, 2'd2, 64'h01234568},
        '{64'h0123456789ABCDEF, 64'h8, 8'h00, 16'h0010, 2'd0, 64'hEF},
        '{64'h0123456789ABCDEF, 64'h100, 8'h00, 16'h0011, 2'd0, 64'hCD},
        '{64'h0123456789ABCDEF, 64'h0, 8'h04, 16'h0020, 2'd0, 64'hEF},
        '{64'h0123456789ABCDEF, 64'h0, 8'h80, 16'h0030, 2'd1, 64'hCDEF},
        '{64'h0123456789ABCDEF, 64'h3, 8'h00, 16'h0010, 2'd0, 64'hEF},
        '{64'h0123456789ABCDEF, 64'h10000000000, 8'h01, 16'h0040, 2'd2, 64'h0},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0018, 2'd3, 64'h0123456789ABCDEF},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0013, 2'd1, 64'h1111},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h0016, 2'd2, 64'h22222222},
        '{64'h0123456789ABCDEF, 64'h0, 8'h00, 16'h001C, 2'd3, 64'h3},
        '{64'hFFEEDDCCBBAA9988, 64'h0, 8'h00, 16'h7FFF, 2'd0, 64'h00}
    };

    // code defined in R2, built position by position
    function automatic logic [7:0] tb_enc(input logic [63:0] d);
        logic [127:0] cw;
        logic [7:0]   c;
        int           k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        c = '0;
        for (int j = 0; j < 7; j++)
            for (int p = 1; p < 72; p++)
                if (p[j]) c[j] = c[j] ^ cw[p];
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [63:0] exp_word;
        bit          cmp_same, misal, full, unc, exp_wr, exp_sil, exp_rd, rd_seen;
        int          nb, off, errs, lat, cyc;
        logic [AW-4:0] seen_rd_addr;
        nb   = 1 << v.size;
        off  = int'(v.addr[2:0]);
        misal = (off % nb) != 0;
        full  = (v.size == 2'd3) && !misal;
        errs  = $countones(v.fdat) + $countones(v.fchk);
        unc   = errs >= 2;
        exp_word = v.old;
        cmp_same = 1'b1;
        if (full) exp_word = v.sdat;
        else for (int b = 0; b < nb; b++) begin
            if (exp_word[(off + b) * 8 +: 8] != v.sdat[b * 8 +: 8]) cmp_same = 1'b0;
            exp_word[(off + b) * 8 +: 8] = v.sdat[b * 8 +: 8];
        end
        exp_rd  = !misal && !full;
        exp_sil = exp_rd && !unc && cmp_same;
        exp_wr  = full || (exp_rd && !unc && (!cmp_same || errs == 1));
        lat     = exp_rd ? 3 : 1;

        @(negedge clk);
        check(ready == 1'b1, "R3 ready before offer", 64'(ready), 64'd1);
        rd_data  = v.old ^ v.fdat;
        rd_chk   = tb_enc(v.old) ^ v.fchk;
        st_addr  = v.addr;
        st_size  = v.size;
        st_data  = v.sdat;
        st_valid = 1'b1;
        @(negedge clk);
        st_valid = 1'b0;
        cyc = 1;
        rd_seen = 1'b0;
        seen_rd_addr = '0;
        while (!done && cyc < 10) begin
            if (rd_req) begin rd_seen = 1'b1; seen_rd_addr = rd_addr; end
            @(negedge clk);
            cyc++;
        end
        check(cyc == lat, exp_rd ? "R3 latency" : (misal ? "R8 latency" : "R9 latency"), 64'(cyc), 64'(lat));
        check(rd_seen == exp_rd, misal ? "R8 no read" : (full ? "R9 no read" : "R3 read issued"),
              64'(rd_seen), 64'(exp_rd));
        if (exp_rd)
            check(seen_rd_addr == v.addr[AW-1:3], "R4 read address", 64'(seen_rd_addr), 64'(v.addr[AW-1:3]));
        check(wr_req == exp_wr,
              errs == 1 ? "R6 write forced" : (unc ? "R7 no write" : (misal ? "R8 no write" : (full ? "R9 write" : "R5 write"))),
              64'(wr_req), 64'(exp_wr));
        check(silent == exp_sil, errs == 1 ? "R6 silent flag" : "R5 silent flag", 64'(silent), 64'(exp_sil));
        check(uncorr_err == (exp_rd && unc), "R7 error flag", 64'(uncorr_err), 64'(exp_rd && unc));
        check(misalign == misal, "R8 misalign flag", 64'(misalign), 64'(misal));
        if (exp_wr) begin
            check(wr_data == exp_word, errs == 1 ? "R6 corrected merge" : "R4 merged data", wr_data, exp_word);
            check(wr_chk == tb_enc(exp_word), "R2 check bits", 64'(wr_chk), 64'(tb_enc(exp_word)));
            check(wr_addr == v.addr[AW-1:3], "R4 write address", 64'(wr_addr), 64'(v.addr[AW-1:3]));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(ready && !rd_req && !wr_req && !done, "R1 during reset",
              {60'b0, ready, rd_req, wr_req, done}, 64'h8);
        rst = 1'b0;
        @(negedge clk);
        check(ready && !rd_req && !wr_req && !done, "R1 after reset",
              {60'b0, ready, rd_req, wr_req, done}, 64'h8);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3: a store offered while busy is ignored
        @(negedge clk);
        rd_data  = 64'h0123456789ABCDEF;
        rd_chk   = tb_enc(64'h0123456789ABCDEF);
        st_addr  = 16'h0010;
        st_size  = 2'd0;
        st_data  = 64'hEF;
        st_valid = 1'b1;
        @(negedge clk);
        st_size = 2'd3;
        st_data = 64'hDEADBEEFDEADBEEF;
        while (!done) @(negedge clk);
        check(silent && !wr_req, "R3 busy offer leaves result", {62'b0, silent, wr_req}, 64'h2);
        st_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(ready && !rd_req && !wr_req && !done, "R3 busy offer not accepted",
                  {60'b0, ready, rd_req, wr_req, done}, 64'h8);
        end

        // R1: reset mid-operation
        st_addr  = 16'h0020;
        st_size  = 2'd1;
        st_data  = 64'h1234;
        st_valid = 1'b1;
        @(negedge clk);
        st_valid = 1'b0;
        check(rd_req == 1'b1, "R3 read after accept", 64'(rd_req), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        check(ready && !rd_req && !done, "R1 reset aborts", {61'b0, ready, rd_req, done}, 64'h4);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!done && !wr_req, "R1 no completion after reset", {62'b0, done, wr_req}, 64'h0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule